// File: doc/BRIEF.md
# Key-Guarded Clock Control Register Unlock

This block guards two clock-system control registers on a simple memory-mapped write bus: a clock-mode register and a power/divider register. Neither register can be changed by a plain write. Each has its own pair of key locations, and a change lands only when three writes arrive in a fixed order. The first is an opening key value, then the new data to the register itself, then a closing key value. Idle bus cycles may sit between these steps. Any other write in between cancels the attempt.

The new data is held privately while the sequence is open. It is copied into the visible register only when the correct closing key arrives. At that moment a one-cycle commit strobe tells downstream clock logic that a confirmed value has landed. Reads of the register locations always return the committed value.

The address is split into a channel field in bits [3:2] and a slot field in bits [1:0]. Channel 0 is the clock-mode register and channel 1 is the power/divider register. Slot 0 is the data register, slot 1 the opening key and slot 2 the closing key. Writes anywhere else, including channels 2 and 3 and slot 3, are still bus writes and cancel open sequences.

Top module: `key_guard`

## Requirements
- R1: The clock-mode register changes only through this order of writes: 0xAA to address 0x1, then the data to address 0x0, then 0x55 to address 0x2. After the closing write it holds that data.
- R2: The power/divider register changes only through this order of writes: 0x01 to address 0x5, then the data to address 0x4, then 0xF4 to address 0x6. After the closing write it holds that data.
- R3: After reset the clock-mode register reads 0x00. The power/divider register reads 0x03, which is divider code 3 in bits [2:0]. Both commit strobes are low.
- R4: A wrong value written to the opening key, or to the closing key, ends the attempt and leaves the register unchanged.
- R5: During an open sequence, any write other than the next expected step cancels it and discards the held data. This includes unused addresses and repeated steps. A later closing key then commits nothing.
- R6: A data write to a register that was not first opened by its key has no effect.
- R7: A read of address 0x0 or 0x4 returns the committed register value, also while new data is held but not yet confirmed. Reads of key and unused addresses return 0.
- R8: Each commit raises that register's strobe for exactly one cycle, in the cycle that follows the clock edge that takes the closing key write. The register output changes at that same edge.
- R9: The two sequences are tracked separately. Interleaving their steps cancels both, and the two strobes are never high together.
- R10: Cycles with no bus write leave an open sequence where it stands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Write strobe, one write per cycle it is high |
| bus_addr | input | 4 | Word address: channel in [3:2], slot in [1:0] |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| clk_mode | output | 8 | Committed clock-mode register |
| clk_mode_commit | output | 1 | One-cycle pulse when clk_mode takes a confirmed value |
| pwr_ctrl | output | 8 | Committed power/divider register |
| pwr_ctrl_commit | output | 1 | One-cycle pulse when pwr_ctrl takes a confirmed value |

## Verification
A sequencer stuck in the wrong state shows up at the ports as a missing or an unexpected commit. The register output and its strobe both react at the edge that takes the closing key, so each error is visible one cycle after that write. Held data leaking out would show on the register output or on a read of the data address before the closing key. A channel that ignores an abort would commit on a later closing key that should do nothing. Random write streams with mutated steps, checked after every write against a bench model, expose each of these faults within the write that triggers it.

// File: rtl/key_guard_pkg.sv
`timescale 1ns/1ps
package key_guard_pkg;

  // Progress of one guarded register through its unlock order
  typedef enum logic [1:0] {
    KG_IDLE   = 2'd0,
    KG_ARMED  = 2'd1,
    KG_LOADED = 2'd2
  } kg_state_e;

  // Slot positions inside a channel's address window
  localparam int KG_SLOT_W     = 2;
  localparam int KG_SLOT_CTRL  = 0;
  localparam int KG_SLOT_OPEN  = 1;
  localparam int KG_SLOT_CLOSE = 2;

  // Number of guarded registers
  localparam int KG_NCH = 2;

endpackage

// File: rtl/key_guard_rst_sync.sv
`timescale 1ns/1ps
module key_guard_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  // Assert asynchronously, release after STAGES clean edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/key_guard_seq.sv
`timescale 1ns/1ps
module key_guard_seq
  import key_guard_pkg::*;
#(
  parameter int                 DATA_W    = 8,
  parameter logic [DATA_W-1:0]  OPEN_KEY  = '0,
  parameter logic [DATA_W-1:0]  CLOSE_KEY = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              hit_ctrl,
  input  logic              hit_open,
  input  logic              hit_close,
  input  logic [DATA_W-1:0] wdata,
  output logic              commit_req,
  output logic [DATA_W-1:0] commit_data
);

  kg_state_e         state_q, state_d;
  logic [DATA_W-1:0] pend_q, pend_d;
  logic              pend_en;

  wire open_ok  = wr_en && hit_open  && (wdata == OPEN_KEY);
  wire close_ok = wr_en && hit_close && (wdata == CLOSE_KEY);

  // Next-state and held-data decisions
  always_comb begin
    state_d    = state_q;
    pend_d     = pend_q;
    pend_en    = 1'b0;
    commit_req = 1'b0;
    unique case (state_q)
      KG_IDLE: begin
        if (open_ok) state_d = KG_ARMED;
      end
      KG_ARMED: begin
        if (wr_en) begin
          pend_en = 1'b1;
          if (hit_ctrl) begin
            state_d = KG_LOADED;
            pend_d  = wdata;
          end else begin
            state_d = KG_IDLE;
            pend_d  = '0;
          end
        end
      end
      KG_LOADED: begin
        if (wr_en) begin
          state_d    = KG_IDLE;
          pend_en    = 1'b1;
          pend_d     = '0;
          commit_req = close_ok;
        end
      end
      default: begin
        state_d = KG_IDLE;
        pend_en = 1'b1;
        pend_d  = '0;
      end
    endcase
  end

  // When commit_req is high, pend_q still holds the confirmed data
  assign commit_data = pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= KG_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= '0;
    else if (pend_en) pend_q <= pend_d;
  end

  // R1 / R2: arming only follows a correct opening key write
  p_arm_by_key_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == KG_ARMED && $past(state_q) != KG_ARMED) |->
      $past(wr_en && hit_open && wdata == OPEN_KEY));

  // R6: held data only ever follows the armed step
  p_load_after_arm_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == KG_LOADED && $past(state_q) != KG_LOADED) |->
      $past(state_q) == KG_ARMED);

  // R10: no write, no movement
  p_idle_bus_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(state_q));

endmodule

// File: rtl/key_guard_reg.sv
`timescale 1ns/1ps
module key_guard_reg #(
  parameter int                DATA_W    = 8,
  parameter logic [DATA_W-1:0] RESET_VAL = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit_req,
  input  logic [DATA_W-1:0] commit_data,
  output logic [DATA_W-1:0] value_q,
  output logic              strobe_q
);

  logic              value_en;
  logic [DATA_W-1:0] value_d;

  always_comb begin
    value_en = commit_req;
    value_d  = commit_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        value_q <= RESET_VAL;
    else if (value_en) value_q <= value_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe_q <= 1'b0;
    else        strobe_q <= commit_req;
  end

  // R7: committed value only moves on a confirmed commit
  p_hold_without_commit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_req |=> $stable(value_q));

  // R8: a commit pulse never lasts two cycles
  p_pulse_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_q |=> !strobe_q);

endmodule

// File: rtl/key_guard.sv
`timescale 1ns/1ps
module key_guard
  import key_guard_pkg::*;
#(
  parameter int                ADDR_W        = 4,
  parameter int                DATA_W        = 8,
  parameter logic [DATA_W-1:0] CLK_OPEN_KEY  = 8'hAA,
  parameter logic [DATA_W-1:0] CLK_CLOSE_KEY = 8'h55,
  parameter logic [DATA_W-1:0] CLK_RESET     = 8'h00,
  parameter logic [DATA_W-1:0] PWR_OPEN_KEY  = 8'h01,
  parameter logic [DATA_W-1:0] PWR_CLOSE_KEY = 8'hF4,
  parameter logic [DATA_W-1:0] PWR_RESET     = 8'h03
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [DATA_W-1:0] clk_mode,
  output logic              clk_mode_commit,
  output logic [DATA_W-1:0] pwr_ctrl,
  output logic              pwr_ctrl_commit
);

  localparam int CHAN_W = ADDR_W - KG_SLOT_W;

  logic rst_sync_n;

  key_guard_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  logic [CHAN_W-1:0]    addr_chan;
  logic [KG_SLOT_W-1:0] addr_slot;

  assign addr_chan = bus_addr[ADDR_W-1:KG_SLOT_W];
  assign addr_slot = bus_addr[KG_SLOT_W-1:0];

  logic [DATA_W-1:0] val_q    [KG_NCH];
  logic              strobe_q [KG_NCH];

  for (genvar g = 0; g < KG_NCH; g++) begin : g_chan
    localparam logic [DATA_W-1:0] G_OPEN  = (g == 0) ? CLK_OPEN_KEY  : PWR_OPEN_KEY;
    localparam logic [DATA_W-1:0] G_CLOSE = (g == 0) ? CLK_CLOSE_KEY : PWR_CLOSE_KEY;
    localparam logic [DATA_W-1:0] G_RESET = (g == 0) ? CLK_RESET     : PWR_RESET;

    logic              sel, hit_ctrl, hit_open, hit_close;
    logic              commit_req;
    logic [DATA_W-1:0] commit_data;

    assign sel       = (addr_chan == CHAN_W'(g));
    assign hit_ctrl  = sel && (addr_slot == KG_SLOT_W'(KG_SLOT_CTRL));
    assign hit_open  = sel && (addr_slot == KG_SLOT_W'(KG_SLOT_OPEN));
    assign hit_close = sel && (addr_slot == KG_SLOT_W'(KG_SLOT_CLOSE));

    key_guard_seq #(
      .DATA_W    (DATA_W),
      .OPEN_KEY  (G_OPEN),
      .CLOSE_KEY (G_CLOSE)
    ) u_seq (
      .clk         (clk),
      .rst_n       (rst_sync_n),
      .wr_en       (bus_wr),
      .hit_ctrl    (hit_ctrl),
      .hit_open    (hit_open),
      .hit_close   (hit_close),
      .wdata       (bus_wdata),
      .commit_req  (commit_req),
      .commit_data (commit_data)
    );

    key_guard_reg #(
      .DATA_W    (DATA_W),
      .RESET_VAL (G_RESET)
    ) u_reg (
      .clk         (clk),
      .rst_n       (rst_sync_n),
      .commit_req  (commit_req),
      .commit_data (commit_data),
      .value_q     (val_q[g]),
      .strobe_q    (strobe_q[g])
    );
  end

  // Reads see only committed values; keys and holes read as zero
  always_comb begin
    bus_rdata = '0;
    for (int g = 0; g < KG_NCH; g++) begin
      if (addr_chan == CHAN_W'(g) && addr_slot == KG_SLOT_W'(KG_SLOT_CTRL))
        bus_rdata = val_q[g];
    end
  end

  assign clk_mode        = val_q[0];
  assign clk_mode_commit = strobe_q[0];
  assign pwr_ctrl        = val_q[1];
  assign pwr_ctrl_commit = strobe_q[1];

  // R9: one write per cycle can confirm at most one register
  p_single_commit_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(clk_mode_commit && pwr_ctrl_commit));

  // R8: a strobe always follows a bus write
  p_strobe_after_write_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (clk_mode_commit || pwr_ctrl_commit) |-> $past(bus_wr));

endmodule

// File: tb/key_guard_test.sv
`timescale 1ns/1ps
module key_guard_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       bus_wr;
  logic [3:0] bus_addr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic [7:0] clk_mode, pwr_ctrl;
  logic       clk_mode_commit, pwr_ctrl_commit;

  always #10 clk = ~clk;

  key_guard uut (
    .clk             (clk),
    .rst_n           (rst_n),
    .bus_wr          (bus_wr),
    .bus_addr        (bus_addr),
    .bus_wdata       (bus_wdata),
    .bus_rdata       (bus_rdata),
    .clk_mode        (clk_mode),
    .clk_mode_commit (clk_mode_commit),
    .pwr_ctrl        (pwr_ctrl),
    .pwr_ctrl_commit (pwr_ctrl_commit)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // Bench model of the requirements
  int         m_st   [2];
  logic [7:0] m_pend [2];
  logic [7:0] m_comm [2];
  logic       m_strb [2];

  function automatic logic [7:0] okey(int ch);
    return (ch == 0) ? 8'hAA : 8'h01;
  endfunction

  function automatic logic [7:0] ckey(int ch);
    return (ch == 0) ? 8'h55 : 8'hF4;
  endfunction

  function automatic logic [3:0] addr_of(int ch, int slot);
    return 4'(ch * 4 + slot);
  endfunction

  task automatic chk(string req, string ctx, logic [7:0] got, logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s (%s): got=%h expected=%h", req, ctx, got, exp);
    end
  endtask

  task automatic model_write(logic [3:0] a, logic [7:0] d);
    for (int g = 0; g < 2; g++) begin
      m_strb[g] = 1'b0;
      case (m_st[g])
        0: if (a == addr_of(g, 1) && d == okey(g)) m_st[g] = 1;
        1: begin
          if (a == addr_of(g, 0)) begin m_st[g] = 2; m_pend[g] = d; end
          else m_st[g] = 0;
        end
        default: begin
          if (a == addr_of(g, 2) && d == ckey(g)) begin
            m_comm[g] = m_pend[g];
            m_strb[g] = 1'b1;
          end
          m_st[g] = 0;
        end
      endcase
    end
  endtask

  task automatic check_outputs(string ctx);
    chk("R1", ctx, clk_mode, m_comm[0]);
    chk("R2", ctx, pwr_ctrl, m_comm[1]);
    chk("R8", ctx, {7'd0, clk_mode_commit}, {7'd0, m_strb[0]});
    chk("R8", ctx, {7'd0, pwr_ctrl_commit}, {7'd0, m_strb[1]});
    bus_addr = addr_of(0, 0);
    #1;
    chk("R7", ctx, bus_rdata, m_comm[0]);
    bus_addr = addr_of(1, 0);
    #1;
    chk("R7", ctx, bus_rdata, m_comm[1]);
  endtask

  // Write is held across one rising edge; outputs sampled at the next falling edge
  task automatic do_write(logic [3:0] a, logic [7:0] d, string ctx);
    @(negedge clk);
    bus_wr    = 1'b1;
    bus_addr  = a;
    bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    model_write(a, d);
    check_outputs(ctx);
  endtask

  task automatic seq3(int ch, logic [7:0] v, string ctx);
    do_write(addr_of(ch, 1), okey(ch), ctx);
    do_write(addr_of(ch, 0), v, ctx);
    do_write(addr_of(ch, 2), ckey(ch), ctx);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: got=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed_init;
    seed_init = $urandom(32'd20517);
    rst_n     = 1'b0;
    bus_wr    = 1'b0;
    bus_addr  = '0;
    bus_wdata = '0;
    for (int g = 0; g < 2; g++) begin
      m_st[g] = 0; m_pend[g] = '0; m_strb[g] = 1'b0;
    end
    m_comm[0] = 8'h00;
    m_comm[1] = 8'h03;

    repeat (3) @(negedge clk);
    check_outputs("R3 reset state");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_outputs("R3 after release");

    // R1 / R2 clean sequences
    seq3(0, 8'h5A, "R1 clean clock-mode write");
    seq3(1, 8'h27, "R2 clean power write");

    // R4 wrong opening key
    do_write(addr_of(0, 1), 8'hAB, "R4 wrong open key");
    do_write(addr_of(0, 0), 8'h11, "R4 data after wrong key");
    do_write(addr_of(0, 2), 8'h55, "R4 close after wrong key");

    // R4 wrong closing key, R7 read while data is held
    do_write(addr_of(1, 1), 8'h01, "R4 open");
    do_write(addr_of(1, 0), 8'hC6, "R7 pending not visible");
    do_write(addr_of(1, 2), 8'hF5, "R4 wrong close key");

    // R5 stray write to an unused address, then a repeated step
    do_write(addr_of(0, 1), 8'hAA, "R5 open");
    do_write(addr_of(0, 0), 8'h77, "R5 data");
    do_write(4'hC, 8'h00, "R5 stray write");
    do_write(addr_of(0, 2), 8'h55, "R5 close after abort");
    do_write(addr_of(1, 1), 8'h01, "R5 open");
    do_write(addr_of(1, 1), 8'h01, "R5 repeated open");
    do_write(addr_of(1, 0), 8'h99, "R5 data after repeat");
    do_write(addr_of(1, 2), 8'hF4, "R5 close after repeat");

    // R6 unopened data write
    do_write(addr_of(0, 0), 8'h3C, "R6 direct data write");
    do_write(addr_of(0, 2), 8'h55, "R6 close with no open");

    // R9 interleaved sequences
    do_write(addr_of(0, 1), 8'hAA, "R9 clock open");
    do_write(addr_of(1, 1), 8'h01, "R9 power open");
    do_write(addr_of(0, 0), 8'hE1, "R9 clock data");
    do_write(addr_of(1, 0), 8'hE2, "R9 power data");
    do_write(addr_of(0, 2), 8'h55, "R9 clock close");
    do_write(addr_of(1, 2), 8'hF4, "R9 power close");

    // R10 idle gaps between steps
    do_write(addr_of(1, 1), 8'h01, "R10 open");
    repeat (5) @(negedge clk);
    do_write(addr_of(1, 0), 8'h4B, "R10 data after gap");
    repeat (7) @(negedge clk);
    do_write(addr_of(1, 2), 8'hF4, "R10 close after gap");

    // R7 key and unused addresses read as zero
    @(negedge clk);
    for (int s = 1; s < 4; s++) begin
      bus_addr = addr_of(0, s);
      #1;
      chk("R7", "key/unused read", bus_rdata, 8'h00);
      bus_addr = addr_of(1, s);
      #1;
      chk("R7", "key/unused read", bus_rdata, 8'h00);
    end

    // Random sequences with occasional mutated steps (R4, R5, R9)
    for (int it = 0; it < 400; it++) begin
      int         ch;
      logic [7:0] val;
      ch  = int'($urandom_range(1, 0));
      val = 8'($urandom);
      for (int s = 0; s < 3; s++) begin
        logic [3:0] a;
        logic [7:0] d;
        case (s)
          0:       begin a = addr_of(ch, 1); d = okey(ch); end
          1:       begin a = addr_of(ch, 0); d = val;      end
          default: begin a = addr_of(ch, 2); d = ckey(ch); end
        endcase
        if ($urandom_range(9, 0) == 0) a = 4'($urandom);
        if ($urandom_range(9, 0) == 0) d = 8'($urandom);
        do_write(a, d, "R5 random stream");
        repeat ($urandom_range(2, 0)) @(negedge clk);
      end
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule